// File: doc/BRIEF.md
# Binary Add Unit with Variant-Specific Flag Rules

This block is the binary addition datapath of a processor execution stage. One of four addition variants is chosen per cycle: a plain add, an add into an address register, an add of a small literal held in the instruction ("quick"), and an add that also takes in the extend flag for multi-precision chains. Each variant has its own rules. They decide how the source operand is widened, how much of the destination is rewritten, and whether the five condition flags (extend X, negative N, zero Z, overflow V, carry C) change at all.

The caller supplies the already-fetched source and destination values, the variant, the operand size and whether the destination is an address register. The unit returns, one clock later, the value to write back into the destination and the next flag state. Illegal variant/size combinations are reported on an error output. In that case the destination and the flags pass through unchanged. The register file, address calculation and memory access are outside this block.

Top module: `addu_unit`

## Requirements
- R1: While reset is asserted and after its release with no clock edge yet sampled, `res_o`, `flags_o` and `err_o` are all zero.
- R2: A plain add (op code 0) takes the size from `size_i` (0 byte, 1 word, 2 longword). It computes source plus destination at that size, and the flags follow R9.
- R3: An add into an address register (op code 1) sign-extends a word source from bit 15 to 32 bits, or uses a longword source as is. It adds this to the full 32-bit destination, rewrites all 32 bits and leaves all five flags unchanged.
- R4: For a quick add (op code 2) the source is the 3-bit `quick_i` field. Values 1 to 7 stand for themselves and 0 stands for 8.
- R5: A quick add with `dst_is_addr_i` set adds the literal to all 32 bits of the destination, whatever the size, and leaves all flags unchanged.
- R6: An add with extend (op code 3) computes source plus destination plus the incoming X flag at the chosen size.
- R7: For an add with extend, Z becomes 0 when the sized result is nonzero and otherwise keeps its incoming value.
- R8: For a byte or word operation that writes a data destination (op codes 0 and 3, and op code 2 without `dst_is_addr_i`), only the low 8 or 16 bits are replaced. The upper destination bits are kept.
- R9: When the flags update, N is the result's top bit at the operation size, V is signed overflow at that size, C is the carry out of that size, and X equals C. Z is set on a zero sized result, except as R7 says. The flag vector is ordered {X,N,Z,V,C} from bit 4 down to bit 0.
- R10: Size code 3 with any op, and op code 1 with byte size, raise `err_o`. The destination is then returned unchanged and the flags keep their incoming value. Every legal combination clears `err_o`.
- R11: Outputs are registered: each result appears on the clock edge after the inputs were presented and holds until the next edge.
- R12: `dst_is_addr_i` has no effect on op codes 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Variant: 0 add, 1 add to address, 2 quick, 3 with extend |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 longword, 3 illegal |
| dst_is_addr_i | input | 1 | Destination is an address register |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Current destination value |
| quick_i | input | 3 | Quick literal field (0 means 8) |
| flags_i | input | 5 | Current flags {X,N,Z,V,C} |
| res_o | output | 32 | Value to write back to the destination |
| flags_o | output | 5 | Next flags {X,N,Z,V,C} |
| err_o | output | 1 | Illegal variant/size combination |

## Verification
The hardest case to reach is the quiet interaction between the incoming flags and the variants that must not touch them. An add with extend has to keep a Z that was already clear across a zero result. The address variants have to hand back an arbitrary flag pattern exactly as it came in. Both need the flag inputs driven as deliberately as the operands. The sweep therefore crosses every op, size and destination type with all four X/Z starting combinations and a varying N/V/C pattern. It uses operands chosen at the sign and carry boundaries of each size (0x7F, 0xFF, 0x7FFF, 0x8002, 0x80000000), so that zero results with carry-in and overflow at every width arise together with each flag state.

// File: rtl/addu_pkg.sv
package addu_pkg;

   typedef enum logic [1:0] {
      OP_ADD   = 2'd0,
      OP_ADDR  = 2'd1,
      OP_QUICK = 2'd2,
      OP_EXT   = 2'd3
   } addu_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_BAD  = 2'd3
   } addu_size_e;

   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } addu_flags_t;

   localparam int unsigned LANES = 3;

endpackage

// File: rtl/addu_operand_prep.sv
module addu_operand_prep
   import addu_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned QUICK_W        = 3,
   parameter bit          QUICK_ZERO_MAX = 1'b1
) (
   input  addu_op_e          op,
   input  addu_size_e        size,
   input  logic              dst_is_addr,
   input  logic [DATA_W-1:0] src,
   input  logic [QUICK_W-1:0] quick,
   input  logic              x_in,
   output logic [DATA_W-1:0] opnd_a,
   output logic              cin,
   output logic [1:0]        lane,
   output logic              full_w,
   output logic              illegal
);

   localparam int unsigned LIT_W = QUICK_W + 1;

   logic [LIT_W-1:0]  lit;
   logic [DATA_W-1:0] src_wext;

   generate
      if (QUICK_ZERO_MAX) begin : g_lit_wrap
         assign lit = (quick == '0) ? LIT_W'(1) << QUICK_W : {1'b0, quick};
      end else begin : g_lit_plain
         assign lit = {1'b0, quick};
      end
   endgenerate

   assign src_wext = {{(DATA_W-16){src[15]}}, src[15:0]};

   always_comb begin
      illegal = (size == SZ_BAD) || (op == OP_ADDR && size == SZ_BYTE);
      opnd_a  = src;
      cin     = 1'b0;
      full_w  = 1'b0;
      lane    = size;
      unique case (op)
         OP_ADDR: begin
            full_w = 1'b1;
            lane   = 2'd2;
            opnd_a = (size == SZ_WORD) ? src_wext : src;
         end
         OP_QUICK: begin
            opnd_a = DATA_W'(lit);
            full_w = dst_is_addr;
            if (dst_is_addr) lane = 2'd2;
         end
         OP_EXT: begin
            cin = x_in;
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/addu_core.sv
module addu_core
   import addu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] dst,
   input  logic              cin,
   input  logic [1:0]        lane,
   output logic [DATA_W-1:0] lane_res,
   output logic              c_out,
   output logic              v_out,
   output logic              n_out,
   output logic              z_out
);

   function automatic int unsigned lane_width(int unsigned g);
      return (g == 0) ? 8 : ((g == 1) ? 16 : DATA_W);
   endfunction

   logic [DATA_W-1:0] res_arr [LANES];
   logic [LANES-1:0]  c_vec;
   logic [LANES-1:0]  v_vec;
   logic [LANES-1:0]  n_vec;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         localparam int unsigned W = lane_width(g);
         logic [W:0] sum;
         assign sum = {1'b0, opnd_a[W-1:0]} + {1'b0, dst[W-1:0]} + (W+1)'(cin);
         assign res_arr[g] = DATA_W'(sum[W-1:0]);
         assign c_vec[g]   = sum[W];
         assign n_vec[g]   = sum[W-1];
         assign v_vec[g]   = (opnd_a[W-1] == dst[W-1]) && (sum[W-1] != opnd_a[W-1]);
      end
   endgenerate

   logic [1:0] idx;
   assign idx      = (lane == 2'd3) ? 2'd2 : lane;
   assign lane_res = res_arr[idx];
   assign c_out    = c_vec[idx];
   assign v_out    = v_vec[idx];
   assign n_out    = n_vec[idx];
   assign z_out    = (lane_res == '0);

endmodule

// File: rtl/addu_flag_unit.sv
module addu_flag_unit
   import addu_pkg::*;
(
   input  addu_op_e    op,
   input  logic        full_w,
   input  logic        illegal,
   input  logic        c_in,
   input  logic        v_in,
   input  logic        n_in,
   input  logic        z_in,
   input  addu_flags_t flags_cur,
   output addu_flags_t flags_nxt
);

   always_comb begin
      flags_nxt = flags_cur;
      if (!illegal && !full_w) begin
         flags_nxt.c = c_in;
         flags_nxt.x = c_in;
         flags_nxt.n = n_in;
         flags_nxt.v = v_in;
         flags_nxt.z = (op == OP_EXT) ? (flags_cur.z & z_in) : z_in;
      end
   end

endmodule

// File: rtl/addu_merge.sv
module addu_merge #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] lane_res,
   input  logic [1:0]        lane,
   input  logic              full_w,
   input  logic              illegal,
   output logic [DATA_W-1:0] res
);

   logic [DATA_W-1:0] keep_mask;

   always_comb begin
      unique case (lane)
         2'd0:    keep_mask = {{(DATA_W-8){1'b1}}, 8'h00};
         2'd1:    keep_mask = {{(DATA_W-16){1'b1}}, 16'h0000};
         default: keep_mask = '0;
      endcase
      if (full_w) keep_mask = '0;
   end

   assign res = illegal ? dst : ((dst & keep_mask) | (lane_res & ~keep_mask));

endmodule

// File: rtl/addu_unit.sv
module addu_unit
   import addu_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned QUICK_W        = 3,
   parameter bit          QUICK_ZERO_MAX = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         op_i,
   input  logic [1:0]         size_i,
   input  logic               dst_is_addr_i,
   input  logic [DATA_W-1:0]  src_i,
   input  logic [DATA_W-1:0]  dst_i,
   input  logic [QUICK_W-1:0] quick_i,
   input  logic [4:0]         flags_i,
   output logic [DATA_W-1:0]  res_o,
   output logic [4:0]         flags_o,
   output logic               err_o
);

   generate
      if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("addu_unit: DATA_W must be a multiple of 8 and at least 32");
      end
      if (QUICK_W < 1 || QUICK_W > 8) begin : g_bad_quick
         $error("addu_unit: QUICK_W must lie in 1..8");
      end
   endgenerate

   addu_op_e          op;
   addu_size_e        size;
   addu_flags_t       flags_cur;
   addu_flags_t       flags_nxt;
   logic [DATA_W-1:0] opnd_a;
   logic              cin;
   logic [1:0]        lane;
   logic              full_w;
   logic              illegal;
   logic [DATA_W-1:0] lane_res;
   logic              c_w, v_w, n_w, z_w;
   logic [DATA_W-1:0] res_nxt;

   assign op        = addu_op_e'(op_i);
   assign size      = addu_size_e'(size_i);
   assign flags_cur = addu_flags_t'(flags_i);

   addu_operand_prep #(
      .DATA_W(DATA_W), .QUICK_W(QUICK_W), .QUICK_ZERO_MAX(QUICK_ZERO_MAX)
   ) i_prep (
      .op(op), .size(size), .dst_is_addr(dst_is_addr_i), .src(src_i),
      .quick(quick_i), .x_in(flags_cur.x), .opnd_a(opnd_a), .cin(cin),
      .lane(lane), .full_w(full_w), .illegal(illegal)
   );

   addu_core #(.DATA_W(DATA_W)) i_core (
      .opnd_a(opnd_a), .dst(dst_i), .cin(cin), .lane(lane),
      .lane_res(lane_res), .c_out(c_w), .v_out(v_w), .n_out(n_w), .z_out(z_w)
   );

   addu_flag_unit i_flags (
      .op(op), .full_w(full_w), .illegal(illegal), .c_in(c_w), .v_in(v_w),
      .n_in(n_w), .z_in(z_w), .flags_cur(flags_cur), .flags_nxt(flags_nxt)
   );

   addu_merge #(.DATA_W(DATA_W)) i_merge (
      .dst(dst_i), .lane_res(lane_res), .lane(lane), .full_w(full_w),
      .illegal(illegal), .res(res_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o   <= '0;
         flags_o <= '0;
         err_o   <= 1'b0;
      end else begin
         res_o   <= res_nxt;
         flags_o <= flags_nxt;
         err_o   <= illegal;
      end
   end

endmodule

// File: rtl/addu_unit_chk.sv
module addu_unit_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        op_i,
   input logic [1:0]        size_i,
   input logic              dst_is_addr_i,
   input logic [DATA_W-1:0] dst_i,
   input logic [4:0]        flags_i,
   input logic [DATA_W-1:0] res_o,
   input logic [4:0]        flags_o,
   input logic              err_o
);

   logic bad_combo;
   assign bad_combo = (size_i == 2'd3) || (op_i == 2'd1 && size_i == 2'd0);

   AST_ADDR_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd1 && !bad_combo) |=> (flags_o == $past(flags_i)));  // R3

   AST_QUICK_AREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd2 && dst_is_addr_i && !bad_combo) |=> (flags_o == $past(flags_i)));  // R5

   AST_X_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
      (!bad_combo && (op_i == 2'd0 || op_i == 2'd3 || (op_i == 2'd2 && !dst_is_addr_i)))
      |=> (flags_o[4] == flags_o[0]));  // R9

   AST_EXT_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd3 && !bad_combo && !flags_i[2]) |=> !flags_o[2]);  // R7

   AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      bad_combo |=> (err_o && res_o == $past(dst_i) && flags_o == $past(flags_i)));  // R10

   AST_LEGAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_combo |=> !err_o);  // R10

   AST_BYTE_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == 2'd0 || op_i == 2'd3) && size_i == 2'd0)
      |=> (res_o[DATA_W-1:8] == $past(dst_i[DATA_W-1:8])));  // R8

endmodule

bind addu_unit addu_unit_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
   .dst_is_addr_i(dst_is_addr_i), .dst_i(dst_i), .flags_i(flags_i),
   .res_o(res_o), .flags_o(flags_o), .err_o(err_o)
);

// File: tb/test_addu_unit.sv
module test_addu_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic        dst_is_addr_i = 1'b0;
   logic [31:0] src_i = '0;
   logic [31:0] dst_i = '0;
   logic [2:0]  quick_i = '0;
   logic [4:0]  flags_i = '0;
   logic [31:0] res_o;
   logic [4:0]  flags_o;
   logic        err_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   addu_unit i_addu_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
      .dst_is_addr_i(dst_is_addr_i), .src_i(src_i), .dst_i(dst_i),
      .quick_i(quick_i), .flags_i(flags_i), .res_o(res_o),
      .flags_o(flags_o), .err_o(err_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [1:0] op, input logic [1:0] sz, input logic da,
                        input logic [31:0] s, input logic [31:0] d, input logic [2:0] q,
                        input logic [4:0] f, output logic [31:0] er, output logic [4:0] ef,
                        output logic ee, output string rtag, output string ftag);
      longint unsigned lit, mask, a, b, sum, r;
      int w;
      logic c, n, v, z;
      lit = (q == 3'd0) ? 64'd8 : 64'(q);
      ee  = (sz == 2'd3) || (op == 2'd1 && sz == 2'd0);
      if (ee) begin
         er = d; ef = f; rtag = "R10"; ftag = "R10";
      end else if (op == 2'd1) begin
         a  = (sz == 2'd1) ? (s[15] ? (64'hFFFF0000 | 64'(s[15:0])) : 64'(s[15:0])) : 64'(s);
         er = 32'(64'(d) + a); ef = f; rtag = da ? "R12" : "R3"; ftag = "R3";
      end else if (op == 2'd2 && da) begin
         er = 32'(64'(d) + lit); ef = f; rtag = "R5"; ftag = "R5";
      end else begin
         w    = (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
         mask = (64'd1 << w) - 64'd1;
         a    = (op == 2'd2) ? lit : (64'(s) & mask);
         b    = 64'(d) & mask;
         sum  = a + b + ((op == 2'd3) ? 64'(f[4]) : 64'd0);
         r    = sum & mask;
         c    = sum[w];
         n    = r[w-1];
         v    = (a[w-1] == b[w-1]) && (n != a[w-1]);
         z    = (r == 0);
         if (op == 2'd3) z = f[2] & z;
         er   = 32'((64'(d) & ~mask) | r);
         ef   = {c, n, z, v, c};
         if (op == 2'd2) rtag = "R4";
         else if (op == 2'd3) rtag = "R6";
         else if (da) rtag = "R12";
         else if (sz != 2'd2) rtag = "R8";
         else rtag = "R2";
         ftag = (op == 2'd3) ? "R7" : "R9";
      end
   endtask

   task automatic run_vec(input logic [1:0] op, input logic [1:0] sz, input logic da,
                          input logic [31:0] s, input logic [31:0] d, input logic [2:0] q,
                          input logic [4:0] f);
      logic [31:0] er; logic [4:0] ef; logic ee; string rtag, ftag;
      model(op, sz, da, s, d, q, f, er, ef, ee, rtag, ftag);
      @(negedge clk);
      op_i = op; size_i = sz; dst_is_addr_i = da; src_i = s; dst_i = d;
      quick_i = q; flags_i = f;
      @(posedge clk);
      #1;
      check(rtag, res_o, er);
      check(ftag, 32'(flags_o), 32'(ef));
      check("R10", 32'(err_o), 32'(ee));
   endtask

   localparam logic [31:0] SRCV [8] = '{32'h0, 32'h1, 32'h7F, 32'hFF, 32'h7FFF,
                                        32'h8002, 32'h8000_0000, 32'hFFFF_FFFF};
   localparam logic [31:0] DSTV [8] = '{32'h0, 32'h100, 32'h7F, 32'hFF, 32'hFFFF,
                                        32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_FF80};

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", res_o, 32'h0);
      check("R1", 32'(flags_o), 32'h0);
      check("R1", 32'(err_o), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Directed corner cases
      run_vec(2'd1, 2'd1, 1'b1, 32'h8002, 32'h100, 3'd0, 5'b10101);    // R3 word sign-extension
      check("R3", res_o, 32'hFFFF_8102);
      run_vec(2'd0, 2'd0, 1'b0, 32'h1, 32'hAAAA_AA7F, 3'd0, 5'b0);     // R9 byte overflow 0x7F+1
      check("R9", 32'(flags_o), 32'b01010);
      run_vec(2'd0, 2'd1, 1'b0, 32'h1, 32'h5555_7FFF, 3'd0, 5'b0);     // R9 word overflow 0x7FFF+1
      check("R9", 32'(flags_o), 32'b01010);
      run_vec(2'd2, 2'd0, 1'b0, 32'h0, 32'h0000_12F8, 3'd0, 5'b0);     // R4: 0 means 8, wraps byte
      check("R4", res_o, 32'h0000_1200);
      run_vec(2'd3, 2'd0, 1'b0, 32'h0, 32'h0000_00FF, 3'd0, 5'b10000); // R7: zero result, Z stays clear
      check("R7", 32'(flags_o), 32'b10001);

      // R11: new inputs presented, output holds the previous result until the edge
      @(negedge clk);
      op_i = 2'd0; size_i = 2'd2; dst_is_addr_i = 1'b0; src_i = 32'h5; dst_i = 32'h6;
      #1;
      check("R11", res_o, 32'h0000_0000);
      @(posedge clk);
      #1;
      check("R11", res_o, 32'h0000_000B);

      // Sweep: all ops, sizes, destination types, X/Z states, boundary operands
      for (int op = 0; op < 4; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int da = 0; da < 2; da++)
               for (int fx = 0; fx < 4; fx++)
                  for (int si = 0; si < 8; si++)
                     for (int di = 0; di < 8; di++) begin
                        logic [4:0] f;
                        f = {fx[1], 1'(si), fx[0], 1'(di), 1'(si ^ di)};
                        if (op == 2)
                           run_vec(2'(op), 2'(sz), 1'(da), SRCV[si], DSTV[di], 3'(si), f);
                        else
                           run_vec(2'(op), 2'(sz), 1'(da), SRCV[si], DSTV[di], 3'(di), f);
                     end

      // Random operands
      for (int k = 0; k < 3000; k++)
         run_vec(2'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom,
                 3'($urandom), 5'($urandom));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule